// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer

This block is the control sequencer of a small 32-bit load/store processor. The processor has one shared ALU and one memory that holds both instructions and data. Each instruction runs over several clock cycles, and the sequencer reuses the ALU and the memory in different cycles. It is a Moore machine with ten encoded states. The state depends on the clock, a synchronous reset and the 6-bit opcode taken from the instruction register. Each cycle it drives the datapath's selects and write enables, and the values depend only on the current state.

Every instruction starts with the same two steps: a fetch that also advances the PC, and a decode that reads the registers and precomputes a branch target. After decode the path splits by instruction class. Loads, stores, register-to-register operations, equality branches and jumps each follow their own fixed path back to fetch. An opcode outside those classes goes straight back to fetch after decode.

Top module: `mcSequencer`

## Requirements
- R1: `rst` is synchronous and active high. A clock edge with `rst` high puts the machine in fetch, whatever state it was in.
- R2: Fetch drives memRdEn=1, instrLoad=1, aluSrcB=1, pcLoad=1, and every other control 0 (so addrFromData=0, aluSrcA=0, aluMode=0, pcSel=0). The next state is always decode.
- R3: Decode drives aluSrcB=3 and every other control 0, including all memory, register and PC write enables. The opcode then selects the next state: 0x00 selects R-type execute, 0x23 or 0x2B selects address compute, 0x04 selects branch execute and 0x02 selects jump.
- R4: Load (0x23) takes 5 cycles. After fetch and decode come three states. Address compute drives aluSrcA=1 and aluSrcB=2. Memory read drives memRdEn=1 and addrFromData=1. Write-back drives regWrEn=1, wbFromMem=1 and dstFromRd=0. Every other control is 0 in each of these states, and write-back returns to fetch.
- R5: Store (0x2B) takes 4 cycles. After fetch, decode and address compute comes one store state that drives memWrEn=1, addrFromData=1 and every other control 0, then returns to fetch.
- R6: R-type (0x00) takes 4 cycles. Execute drives aluSrcA=1, aluSrcB=0 and aluMode=2. Completion drives regWrEn=1, dstFromRd=1 and wbFromMem=0, then returns to fetch. Every other control is 0 in both states.
- R7: Branch-if-equal (0x04) takes 3 cycles. Its execute state drives aluSrcA=1, aluMode=1, pcLoadIfZero=1, pcSel=1 and every other control 0, then returns to fetch.
- R8: Jump (0x02) takes 3 cycles. Its single state drives pcLoad=1, pcSel=2 and every other control 0, then returns to fetch.
- R9: Any other opcode value returns from decode straight to fetch, so the instruction takes 2 cycles.
- R10: The opcode is sampled only when leaving decode and leaving address compute. In every other state a change of the opcode has no effect on the sequence or on the outputs.
- R11: At most one of memRdEn, memWrEn and regWrEn is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| addrFromData | output | 1 | Memory address from the ALU result register instead of the PC |
| memRdEn | output | 1 | Memory read |
| memWrEn | output | 1 | Memory write |
| instrLoad | output | 1 | Load the instruction register |
| aluSrcA | output | 1 | ALU A operand: 0 PC, 1 register A |
| aluSrcB | output | 2 | ALU B operand: 0 register B, 1 constant 4, 2 immediate, 3 shifted immediate |
| aluMode | output | 2 | ALU operation class: 0 add, 1 subtract, 2 function field |
| pcLoad | output | 1 | Unconditional PC write |
| pcLoadIfZero | output | 1 | PC write when the ALU zero flag is set |
| pcSel | output | 2 | PC source: 0 ALU, 1 ALU result register, 2 jump target |
| regWrEn | output | 1 | Register file write |
| dstFromRd | output | 1 | Destination register from the rd field instead of rt |
| wbFromMem | output | 1 | Register write data from the memory data register |

## Verification
The hardest case to bring about from the ports is showing that the opcode is ignored in the states where it is not sampled. A correct sequence under a steady opcode proves nothing about this. The stimulus therefore drives a scrambled opcode in every state except decode and address compute, and checks that the cycle count and the per-cycle outputs still match the class. All 64 opcode values are also swept through decode to cover the return of unknown opcodes to fetch. A reset is applied in the middle of a load to check that the machine drops back to fetch.

// File: rtl/mcCtrlPkg.sv
package mcCtrlPkg;

  typedef enum logic [3:0] {
    ST_FETCH   = 4'd0,
    ST_DECODE  = 4'd1,
    ST_MEMADDR = 4'd2,
    ST_LDREAD  = 4'd3,
    ST_LDBACK  = 4'd4,
    ST_STWRITE = 4'd5,
    ST_REXEC   = 4'd6,
    ST_RDONE   = 4'd7,
    ST_BREXEC  = 4'd8,
    ST_JUMP    = 4'd9
  } seqState_e;

  typedef enum logic [2:0] {
    OC_RTYPE,
    OC_LOAD,
    OC_STORE,
    OC_BEQ,
    OC_JUMP,
    OC_OTHER
  } opClass_e;

  typedef struct packed {
    logic       addrFromData;
    logic       memRdEn;
    logic       memWrEn;
    logic       instrLoad;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic [1:0] aluMode;
    logic       pcLoad;
    logic       pcLoadIfZero;
    logic [1:0] pcSel;
    logic       regWrEn;
    logic       dstFromRd;
    logic       wbFromMem;
  } ctrlStrobes_t;

  localparam logic [1:0] SRCB_REG   = 2'd0;
  localparam logic [1:0] SRCB_FOUR  = 2'd1;
  localparam logic [1:0] SRCB_IMM   = 2'd2;
  localparam logic [1:0] SRCB_SHIMM = 2'd3;

  localparam logic [1:0] MODE_ADD   = 2'd0;
  localparam logic [1:0] MODE_SUB   = 2'd1;
  localparam logic [1:0] MODE_FUNCT = 2'd2;

  localparam logic [1:0] PCS_ALU    = 2'd0;
  localparam logic [1:0] PCS_ALUREG = 2'd1;
  localparam logic [1:0] PCS_JUMP   = 2'd2;

endpackage

// File: rtl/seqOpClassify.sv
module seqOpClassify
  import mcCtrlPkg::*;
#(
  parameter int OPCODE_W = 6,
  parameter logic [OPCODE_W-1:0] OP_RTYPE = 'h00,
  parameter logic [OPCODE_W-1:0] OP_LOAD  = 'h23,
  parameter logic [OPCODE_W-1:0] OP_STORE = 'h2B,
  parameter logic [OPCODE_W-1:0] OP_BEQ   = 'h04,
  parameter logic [OPCODE_W-1:0] OP_JUMP  = 'h02
) (
  input  logic [OPCODE_W-1:0] opcode,
  output opClass_e            opClass
);

  always_comb begin
    if (opcode == OP_RTYPE)      opClass = OC_RTYPE;
    else if (opcode == OP_LOAD)  opClass = OC_LOAD;
    else if (opcode == OP_STORE) opClass = OC_STORE;
    else if (opcode == OP_BEQ)   opClass = OC_BEQ;
    else if (opcode == OP_JUMP)  opClass = OC_JUMP;
    else                         opClass = OC_OTHER;
  end

endmodule

// File: rtl/seqStateReg.sv
module seqStateReg
  import mcCtrlPkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  opClass_e  opClass,
  output seqState_e curState
);

  seqState_e nxtState;

  always_comb begin
    nxtState = ST_FETCH;
    unique case (curState)
      ST_FETCH:  nxtState = ST_DECODE;
      ST_DECODE: begin
        unique case (opClass)
          OC_RTYPE: nxtState = ST_REXEC;
          OC_LOAD,
          OC_STORE: nxtState = ST_MEMADDR;
          OC_BEQ:   nxtState = ST_BREXEC;
          OC_JUMP:  nxtState = ST_JUMP;
          default:  nxtState = ST_FETCH;
        endcase
      end
      ST_MEMADDR: nxtState = (opClass == OC_STORE) ? ST_STWRITE : ST_LDREAD;
      ST_LDREAD:  nxtState = ST_LDBACK;
      ST_REXEC:   nxtState = ST_RDONE;
      default:    nxtState = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_FETCH;
    else     curState <= nxtState;
  end

endmodule

// File: rtl/seqStrobeDecode.sv
module seqStrobeDecode
  import mcCtrlPkg::*;
(
  input  seqState_e    curState,
  output ctrlStrobes_t strobes
);

  always_comb begin
    strobes = '0;
    unique case (curState)
      ST_FETCH: begin
        strobes.memRdEn   = 1'b1;
        strobes.instrLoad = 1'b1;
        strobes.aluSrcB   = SRCB_FOUR;
        strobes.aluMode   = MODE_ADD;
        strobes.pcLoad    = 1'b1;
        strobes.pcSel     = PCS_ALU;
      end
      ST_DECODE: begin
        strobes.aluSrcB = SRCB_SHIMM;
        strobes.aluMode = MODE_ADD;
      end
      ST_MEMADDR: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluSrcB = SRCB_IMM;
        strobes.aluMode = MODE_ADD;
      end
      ST_LDREAD: begin
        strobes.memRdEn      = 1'b1;
        strobes.addrFromData = 1'b1;
      end
      ST_LDBACK: begin
        strobes.regWrEn   = 1'b1;
        strobes.wbFromMem = 1'b1;
      end
      ST_STWRITE: begin
        strobes.memWrEn      = 1'b1;
        strobes.addrFromData = 1'b1;
      end
      ST_REXEC: begin
        strobes.aluSrcA = 1'b1;
        strobes.aluSrcB = SRCB_REG;
        strobes.aluMode = MODE_FUNCT;
      end
      ST_RDONE: begin
        strobes.regWrEn   = 1'b1;
        strobes.dstFromRd = 1'b1;
      end
      ST_BREXEC: begin
        strobes.aluSrcA      = 1'b1;
        strobes.aluSrcB      = SRCB_REG;
        strobes.aluMode      = MODE_SUB;
        strobes.pcLoadIfZero = 1'b1;
        strobes.pcSel        = PCS_ALUREG;
      end
      ST_JUMP: begin
        strobes.pcLoad = 1'b1;
        strobes.pcSel  = PCS_JUMP;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/mcSequencer.sv
module mcSequencer
  import mcCtrlPkg::*;
#(
  parameter int OPCODE_W = 6,
  parameter logic [OPCODE_W-1:0] OP_RTYPE = 'h00,
  parameter logic [OPCODE_W-1:0] OP_LOAD  = 'h23,
  parameter logic [OPCODE_W-1:0] OP_STORE = 'h2B,
  parameter logic [OPCODE_W-1:0] OP_BEQ   = 'h04,
  parameter logic [OPCODE_W-1:0] OP_JUMP  = 'h02
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OPCODE_W-1:0] opcode,
  output logic                addrFromData,
  output logic                memRdEn,
  output logic                memWrEn,
  output logic                instrLoad,
  output logic                aluSrcA,
  output logic [1:0]          aluSrcB,
  output logic [1:0]          aluMode,
  output logic                pcLoad,
  output logic                pcLoadIfZero,
  output logic [1:0]          pcSel,
  output logic                regWrEn,
  output logic                dstFromRd,
  output logic                wbFromMem
);

  opClass_e     opClass;
  seqState_e    curState;
  ctrlStrobes_t strobes;

  seqOpClassify #(
    .OPCODE_W(OPCODE_W),
    .OP_RTYPE(OP_RTYPE),
    .OP_LOAD (OP_LOAD),
    .OP_STORE(OP_STORE),
    .OP_BEQ  (OP_BEQ),
    .OP_JUMP (OP_JUMP)
  ) i_classify (
    .opcode (opcode),
    .opClass(opClass)
  );

  seqStateReg i_stateReg (
    .clk     (clk),
    .rst     (rst),
    .opClass (opClass),
    .curState(curState)
  );

  seqStrobeDecode i_strobeDecode (
    .curState(curState),
    .strobes (strobes)
  );

  assign addrFromData = strobes.addrFromData;
  assign memRdEn      = strobes.memRdEn;
  assign memWrEn      = strobes.memWrEn;
  assign instrLoad    = strobes.instrLoad;
  assign aluSrcA      = strobes.aluSrcA;
  assign aluSrcB      = strobes.aluSrcB;
  assign aluMode      = strobes.aluMode;
  assign pcLoad       = strobes.pcLoad;
  assign pcLoadIfZero = strobes.pcLoadIfZero;
  assign pcSel        = strobes.pcSel;
  assign regWrEn      = strobes.regWrEn;
  assign dstFromRd    = strobes.dstFromRd;
  assign wbFromMem    = strobes.wbFromMem;

endmodule

// File: rtl/mcSequencerChk.sv
module mcSequencerChk #(
  parameter int OPCODE_W = 6
) (
  input logic                clk,
  input logic                rst,
  input logic [OPCODE_W-1:0] opcode,
  input logic                addrFromData,
  input logic                memRdEn,
  input logic                memWrEn,
  input logic                instrLoad,
  input logic                aluSrcA,
  input logic [1:0]          aluSrcB,
  input logic [1:0]          aluMode,
  input logic                pcLoad,
  input logic                pcLoadIfZero,
  input logic [1:0]          pcSel,
  input logic                regWrEn,
  input logic                dstFromRd,
  input logic                wbFromMem
);

  logic inDecode;
  assign inDecode = (aluSrcB == 2'd3) && !aluSrcA;

  logic unknownOp;
  assign unknownOp = !(opcode == 'h00 || opcode == 'h23 || opcode == 'h2B ||
                       opcode == 'h04 || opcode == 'h02);

  // R1
  reset_to_fetch_chk: assert property (@(posedge clk) rst |=> instrLoad && pcLoad);

  // R2
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
    instrLoad |=> inDecode && !instrLoad);

  // R3
  decode_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    inDecode |-> !memWrEn && !regWrEn && !pcLoad && !pcLoadIfZero && !memRdEn);

  // R4
  load_read_then_back_chk: assert property (@(posedge clk) disable iff (rst)
    (memRdEn && addrFromData) |=> regWrEn && wbFromMem && !dstFromRd);

  // R6
  rexec_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    (aluMode == 2'd2) |=> regWrEn && dstFromRd);

  // R7
  branch_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    pcLoadIfZero |=> instrLoad);

  // R8
  jump_then_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (pcLoad && pcSel == 2'd2) |=> instrLoad);

  // R9
  unknown_op_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (inDecode && unknownOp) |=> instrLoad);

  // R11
  single_access_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({memRdEn, memWrEn, regWrEn}));

endmodule

bind mcSequencer mcSequencerChk #(.OPCODE_W(OPCODE_W)) i_mcSequencerChk (
  .clk(clk), .rst(rst), .opcode(opcode),
  .addrFromData(addrFromData), .memRdEn(memRdEn), .memWrEn(memWrEn),
  .instrLoad(instrLoad), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB),
  .aluMode(aluMode), .pcLoad(pcLoad), .pcLoadIfZero(pcLoadIfZero),
  .pcSel(pcSel), .regWrEn(regWrEn), .dstFromRd(dstFromRd),
  .wbFromMem(wbFromMem)
);

// File: tb/test_mcSequencer.sv
module test_mcSequencer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       addrFromData, memRdEn, memWrEn, instrLoad, aluSrcA;
  logic [1:0] aluSrcB, aluMode, pcSel;
  logic       pcLoad, pcLoadIfZero, regWrEn, dstFromRd, wbFromMem;

  int checkCnt = 0;
  int failCnt  = 0;
  bit doneFlag = 0;

  always #2 clk = ~clk;

  mcSequencer i_mcSequencer (
    .clk(clk), .rst(rst), .opcode(opcode),
    .addrFromData(addrFromData), .memRdEn(memRdEn), .memWrEn(memWrEn),
    .instrLoad(instrLoad), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB),
    .aluMode(aluMode), .pcLoad(pcLoad), .pcLoadIfZero(pcLoadIfZero),
    .pcSel(pcSel), .regWrEn(regWrEn), .dstFromRd(dstFromRd),
    .wbFromMem(wbFromMem)
  );

  // Bench-side step names
  localparam int S_F = 0, S_D = 1, S_MA = 2, S_LR = 3, S_LB = 4;
  localparam int S_SW = 5, S_RX = 6, S_RD = 7, S_BX = 8, S_J = 9;

  function automatic logic [15:0] observed();
    return {addrFromData, memRdEn, memWrEn, instrLoad, aluSrcA, aluSrcB,
            aluMode, pcLoad, pcLoadIfZero, pcSel, regWrEn, dstFromRd, wbFromMem};
  endfunction

  // Bits: 15 addr 14 rd 13 wr 12 ir 11 srcA 10:9 srcB 8:7 mode 6 pc 5 pcz 4:3 pcSel 2 rw 1 rd 0 mem
  function automatic logic [15:0] expStrobe(int st);
    logic [15:0] v = '0;
    case (st)
      S_F:  begin v[14] = 1; v[12] = 1; v[10:9] = 2'd1; v[6] = 1; end
      S_D:  v[10:9] = 2'd3;
      S_MA: begin v[11] = 1; v[10:9] = 2'd2; end
      S_LR: begin v[14] = 1; v[15] = 1; end
      S_LB: begin v[2] = 1; v[0] = 1; end
      S_SW: begin v[13] = 1; v[15] = 1; end
      S_RX: begin v[11] = 1; v[8:7] = 2'd2; end
      S_RD: begin v[2] = 1; v[1] = 1; end
      S_BX: begin v[11] = 1; v[8:7] = 2'd1; v[5] = 1; v[4:3] = 2'd1; end
      S_J:  begin v[6] = 1; v[4:3] = 2'd2; end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic checkNow(string tag, int st);
    logic [15:0] exp = expStrobe(st);
    logic [15:0] act = observed();
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s step %0d: actual %h expected %h (op %h)", tag, st, act, exp, opcode);
    end
  endtask

  // Runs one instruction starting at a negedge in fetch; ends at the negedge back in fetch
  task automatic runInstr(logic [5:0] op, bit scramble, string tag);
    int seq[6];
    int len;
    seq[0] = S_F; seq[1] = S_D;
    case (op)
      6'h00: begin seq[2] = S_RX; seq[3] = S_RD; len = 4; end
      6'h23: begin seq[2] = S_MA; seq[3] = S_LR; seq[4] = S_LB; len = 5; end
      6'h2B: begin seq[2] = S_MA; seq[3] = S_SW; len = 4; end
      6'h04: begin seq[2] = S_BX; len = 3; end
      6'h02: begin seq[2] = S_J; len = 3; end
      default: len = 2;
    endcase
    for (int k = 0; k < len; k++) begin
      checkNow((k == 0) ? "R2" : (k == 1) ? "R3" : tag, seq[k]);
      if (seq[k] == S_D || seq[k] == S_MA || !scramble) opcode = op;
      else opcode = op ^ 6'h2F ^ 6'(k);
      @(posedge clk);
      @(negedge clk);
    end
    checkNow(tag, S_F);
    if (!scramble && op != 6'h23 && op != 6'h2B) begin
      checkCnt++;
      if (memRdEn && memWrEn) begin
        failCnt++;
        $display("FAIL R11: actual both memory strobes expected one");
      end
    end
  endtask

  function automatic string classTag(logic [5:0] op);
    case (op)
      6'h23: return "R4";
      6'h2B: return "R5";
      6'h00: return "R6";
      6'h04: return "R7";
      6'h02: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    @(posedge clk);
    @(negedge clk);
    checkNow("R1", S_F);
    rst = 1'b0;
    // Sweep every opcode value through decode
    for (int op = 0; op < 64; op++) runInstr(6'(op), 1'b0, classTag(6'(op)));
    // Opcode changes outside the sampling states (R10)
    runInstr(6'h23, 1'b1, "R10");
    runInstr(6'h2B, 1'b1, "R10");
    runInstr(6'h00, 1'b1, "R10");
    runInstr(6'h04, 1'b1, "R10");
    runInstr(6'h02, 1'b1, "R10");
    runInstr(6'h3F, 1'b1, "R10");
    // Reset in the middle of a load (R1)
    opcode = 6'h23;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    checkNow("R1", S_LR);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    checkNow("R1", S_F);
    rst = 1'b0;
    opcode = 6'h02;
    @(posedge clk); @(negedge clk);
    checkNow("R1", S_D);
    doneFlag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!doneFlag) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule